// File: doc/BRIEF.md
# Flash Command Snooper with Bit Striping

This block sits between a transmit byte queue and one or more parallel serial-flash byte lanes. For every chip-select frame it inspects the first byte sent, treats it as a flash command, and works out how many address and dummy bytes follow. Those bytes must reach every flash device unchanged, so they are duplicated onto all lanes. Once that span is over, the block switches to striped data mode. In that mode each beat takes one byte per lane from the queue, spreads their bits across the lanes, and applies the reverse spreading to the bytes that come back before handing them to the receive queue.

One beat is requested per cycle with `beat_go`. The lane exchange is modelled as same-cycle: the block drives `lane_out` and samples `lane_in` in the cycle of the beat. The receive push and the event pulses follow one cycle later. When no chip select is active, the snooper returns to command checking. Unknown commands put it in a pass-through state, and it stays there until the frame ends.

Top module: `flash_cmd_striper`

## Requirements
- R1: After reset the block is in command-checking mode: `striping` is 0, and `rx_push`, `ev_rx_overflow` and `ev_tx_underflow` are 0.
- R2: Outside striped mode, a beat that fires pops one byte (`tx_pop_cnt`=1). It drives byte 0 of `tx_head` (bits 7:0) on every lane and pushes only lane 0's received byte (`lane_in[7:0]`) as one entry, placed in `rx_data[7:0]` with zero upper bits.
- R3: A command byte of 0x03, 0x02, 0xA2 or 0x32 is followed by 3 duplicated beats. A command of 0x0B, 0x3B, 0x6B or 0xBB is followed by 4, and 0xEB by 6. The beat after these is striped.
- R4: Any other command byte enters pass-through: every later beat of the frame is duplicated and `striping` stays 0.
- R5: In striped mode a beat pops LANES bytes (`tx_pop_cnt`=LANES). With w = `tx_head` (byte 0 in bits 7:0), lane j (`lane_out[8j+7:8j]`) bit k equals w[LANES*k+j].
- R6: In striped mode the received lanes are unspread, so that w[LANES*k+j] = lane j bit k. All LANES bytes are pushed (`rx_push_cnt`=LANES), with the first in `rx_data[7:0]`.
- R7: A cycle with `cs_any` low returns the snooper to command checking at the next edge, whatever its state and whether or not a beat fires.
- R8: If `rx_space` is below the number of bytes a fired beat would push, nothing is pushed and `ev_rx_overflow` pulses one cycle later. The snooper state still advances.
- R9: If `tx_level` is below the bytes a beat needs, nothing is popped or sent and the state holds. `ev_tx_underflow` pulses one cycle later, unless `linear_mode` is 1.
- R10: Without `beat_go` there is no pop, no lane strobe, no push and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_any | input | 1 | High while any chip select is asserted |
| linear_mode | input | 1 | Suppresses the underflow event |
| beat_go | input | 1 | Request one lane beat this cycle |
| tx_level | input | LVL_W | Bytes held in the TX queue |
| tx_head | input | LANES*8 | Oldest TX bytes, oldest in bits 7:0 |
| tx_pop | output | 1 | Pop TX bytes this cycle |
| tx_pop_cnt | output | CNT_W | Number of TX bytes popped |
| lane_out | output | LANES*8 | Byte driven on each lane |
| lane_strobe | output | 1 | Lane bytes valid this cycle |
| lane_in | input | LANES*8 | Byte received on each lane |
| rx_space | input | LVL_W | Free entries in the RX queue |
| rx_push | output | 1 | Push received bytes |
| rx_push_cnt | output | CNT_W | Number of bytes pushed |
| rx_data | output | LANES*8 | Pushed bytes, first in bits 7:0 |
| ev_rx_overflow | output | 1 | Received data dropped |
| ev_tx_underflow | output | 1 | Beat lacked TX bytes |
| striping | output | 1 | Snooper is in striped data mode |

## Verification
The bench builds the block with two lanes and a 9-bit level width, so both the duplicated path and the real two-way bit spreading are exercised, rather than the identity mapping that a single lane gives. Two lanes also make a partial queue possible: one byte present while two are needed. This reaches the striped-mode underflow and overflow cases, where the queue is neither empty nor full. Each command class is followed through its full countdown into striping, and frames are cut short by dropping the chip select.

// File: rtl/snoop_pkg.sv
`timescale 1ns/1ps
package snoop_pkg;

  typedef enum logic [1:0] {
    SN_CHECK  = 2'd0,
    SN_PASS   = 2'd1,
    SN_COUNT  = 2'd2,
    SN_STRIPE = 2'd3
  } snoop_mode_e;

  localparam int SPAN_W = 3;

  // Number of duplicated beats that follow a command byte; 0 = unknown command.
  function automatic logic [SPAN_W-1:0] cmd_span(input logic [7:0] op);
    logic [SPAN_W-1:0] span;
    case (op)
      8'h03, 8'h02, 8'hA2, 8'h32: span = 3'd3;
      8'h0B, 8'h3B, 8'h6B, 8'hBB: span = 3'd4;
      8'hEB:                      span = 3'd6;
      default:                    span = 3'd0;
    endcase
    return span;
  endfunction

endpackage

// File: rtl/snoop_fsm.sv
`timescale 1ns/1ps
module snoop_fsm
  import snoop_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_any,
  input  logic        advance,
  input  logic [7:0]  cmd_byte,
  output snoop_mode_e mode
);

  snoop_mode_e       mode_q, mode_d;
  logic [SPAN_W-1:0] left_q, left_d;
  logic [SPAN_W-1:0] span;

  assign span = cmd_span(cmd_byte);
  assign mode = mode_q;

  always_comb begin
    mode_d = mode_q;
    left_d = left_q;
    if (!cs_any) begin
      mode_d = SN_CHECK;
      left_d = '0;
    end else if (advance) begin
      case (mode_q)
        SN_CHECK: begin
          if (span == '0) begin
            mode_d = SN_PASS;
          end else begin
            mode_d = SN_COUNT;
            left_d = span;
          end
        end
        SN_COUNT: begin
          if (left_q == SPAN_W'(1)) begin
            mode_d = SN_STRIPE;
            left_d = '0;
          end else begin
            left_d = left_q - SPAN_W'(1);
          end
        end
        default: begin
          mode_d = mode_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SN_CHECK;
      left_q <= '0;
    end else begin
      mode_q <= mode_d;
      left_q <= left_d;
    end
  end

endmodule

// File: rtl/lane_striper.sv
`timescale 1ns/1ps
module lane_striper #(
  parameter int LANES   = 2,
  parameter bit INVERSE = 1'b0
) (
  input  logic [LANES*8-1:0] din,
  output logic [LANES*8-1:0] dout
);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    for (genvar k = 0; k < 8; k++) begin : g_bit
      if (INVERSE) begin : g_gather
        assign dout[LANES*k + j] = din[j*8 + k];
      end else begin : g_spread
        assign dout[j*8 + k] = din[LANES*k + j];
      end
    end
  end

endmodule

// File: rtl/flash_cmd_striper.sv
`timescale 1ns/1ps
module flash_cmd_striper
  import snoop_pkg::*;
#(
  parameter int LANES = 2,
  parameter int LVL_W = 9,
  localparam int BYTES_W = LANES * 8,
  localparam int CNT_W   = $clog2(LANES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_any,
  input  logic               linear_mode,
  input  logic               beat_go,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic [BYTES_W-1:0] tx_head,
  output logic               tx_pop,
  output logic [CNT_W-1:0]   tx_pop_cnt,
  output logic [BYTES_W-1:0] lane_out,
  output logic               lane_strobe,
  input  logic [BYTES_W-1:0] lane_in,
  input  logic [LVL_W-1:0]   rx_space,
  output logic               rx_push,
  output logic [CNT_W-1:0]   rx_push_cnt,
  output logic [BYTES_W-1:0] rx_data,
  output logic               ev_rx_overflow,
  output logic               ev_tx_underflow,
  output logic               striping
);

  snoop_mode_e        mode;
  logic               stripe_now;
  logic [CNT_W-1:0]   need;
  logic               have_tx, room_rx, fire;
  logic [BYTES_W-1:0] spread_tx, gather_rx, dup_tx;

  logic               push_d, ovf_d, unf_d;
  logic [CNT_W-1:0]   push_cnt_d;
  logic [BYTES_W-1:0] data_d;

  logic               push_q, ovf_q, unf_q;
  logic [CNT_W-1:0]   push_cnt_q;
  logic [BYTES_W-1:0] data_q;

  snoop_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_any   (cs_any),
    .advance  (fire),
    .cmd_byte (tx_head[7:0]),
    .mode     (mode)
  );

  lane_striper #(.LANES(LANES), .INVERSE(1'b0)) u_spread (
    .din  (tx_head),
    .dout (spread_tx)
  );

  lane_striper #(.LANES(LANES), .INVERSE(1'b1)) u_gather (
    .din  (lane_in),
    .dout (gather_rx)
  );

  assign stripe_now = (mode == SN_STRIPE);
  assign need       = stripe_now ? CNT_W'(LANES) : CNT_W'(1);
  assign have_tx    = (tx_level >= LVL_W'(need));
  assign room_rx    = (rx_space >= LVL_W'(need));
  assign fire       = beat_go && have_tx;
  assign dup_tx     = {LANES{tx_head[7:0]}};

  assign tx_pop      = fire;
  assign tx_pop_cnt  = fire ? need : '0;
  assign lane_strobe = fire;
  assign lane_out    = fire ? (stripe_now ? spread_tx : dup_tx) : '0;
  assign striping    = stripe_now;

  always_comb begin
    push_d     = fire && room_rx;
    ovf_d      = fire && !room_rx;
    unf_d      = beat_go && !have_tx && !linear_mode;
    push_cnt_d = push_d ? need : '0;
    data_d     = stripe_now ? gather_rx : BYTES_W'(lane_in[7:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_q     <= 1'b0;
      ovf_q      <= 1'b0;
      unf_q      <= 1'b0;
      push_cnt_q <= '0;
    end else begin
      push_q     <= push_d;
      ovf_q      <= ovf_d;
      unf_q      <= unf_d;
      push_cnt_q <= push_cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (push_d) begin
      data_q <= data_d;
    end
  end

  assign rx_push         = push_q;
  assign rx_push_cnt     = push_cnt_q;
  assign rx_data         = data_q;
  assign ev_rx_overflow  = ovf_q;
  assign ev_tx_underflow = unf_q;

endmodule

// File: rtl/flash_cmd_striper_chk.sv
`timescale 1ns/1ps
module flash_cmd_striper_chk #(
  parameter int LANES = 2,
  localparam int BYTES_W = LANES * 8,
  localparam int CNT_W   = $clog2(LANES + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_any,
  input logic               beat_go,
  input logic               tx_pop,
  input logic [CNT_W-1:0]   tx_pop_cnt,
  input logic [BYTES_W-1:0] lane_out,
  input logic               lane_strobe,
  input logic               rx_push,
  input logic               ev_rx_overflow,
  input logic               ev_tx_underflow,
  input logic               striping
);

  p_dup_lanes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && !striping) |-> (lane_out == {LANES{lane_out[7:0]}}));

  p_stripe_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && striping) |-> (tx_pop_cnt == CNT_W'(LANES)));

  p_push_after_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> $past(tx_pop));

  p_cs_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_any |=> !striping);

  p_no_push_on_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_push && ev_rx_overflow));

  p_underflow_no_pop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_underflow |-> $past(beat_go && !tx_pop));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_go |-> (!tx_pop && !lane_strobe));

endmodule

bind flash_cmd_striper flash_cmd_striper_chk #(.LANES(LANES)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cs_any          (cs_any),
  .beat_go         (beat_go),
  .tx_pop          (tx_pop),
  .tx_pop_cnt      (tx_pop_cnt),
  .lane_out        (lane_out),
  .lane_strobe     (lane_strobe),
  .rx_push         (rx_push),
  .ev_rx_overflow  (ev_rx_overflow),
  .ev_tx_underflow (ev_tx_underflow),
  .striping        (striping)
);

// File: tb/sim_flash_cmd_striper.sv
`timescale 1ns/1ps
module sim_flash_cmd_striper;

  localparam int LANES = 2;
  localparam int LVL_W = 9;

  logic        clk, rst_n, cs_any, linear_mode, beat_go;
  logic [8:0]  tx_level, rx_space;
  logic [15:0] tx_head, lane_in, lane_out, rx_data;
  logic        tx_pop, lane_strobe, rx_push, ev_rx_overflow, ev_tx_underflow, striping;
  logic [1:0]  tx_pop_cnt, rx_push_cnt;

  flash_cmd_striper #(.LANES(LANES), .LVL_W(LVL_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_any(cs_any), .linear_mode(linear_mode),
    .beat_go(beat_go), .tx_level(tx_level), .tx_head(tx_head),
    .tx_pop(tx_pop), .tx_pop_cnt(tx_pop_cnt), .lane_out(lane_out),
    .lane_strobe(lane_strobe), .lane_in(lane_in), .rx_space(rx_space),
    .rx_push(rx_push), .rx_push_cnt(rx_push_cnt), .rx_data(rx_data),
    .ev_rx_overflow(ev_rx_overflow), .ev_tx_underflow(ev_tx_underflow),
    .striping(striping)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;
  bit mon_en = 0;
  bit done = 0;

  typedef struct {
    bit          push;
    int          cnt;
    logic [15:0] data;
    bit          ovf;
    bit          unf;
    string       tag;
  } exp_t;
  exp_t sb[$];

  // bench reference of snooper state: 0 check, 1 pass, 2 count, 3 stripe
  int m_mode = 0;
  int m_left = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] spread(input logic [15:0] w);
    logic [15:0] o;
    for (int j = 0; j < 2; j++)
      for (int k = 0; k < 8; k++)
        o[j*8+k] = w[2*k+j];
    return o;
  endfunction

  function automatic logic [15:0] gather(input logic [15:0] l);
    logic [15:0] o;
    for (int j = 0; j < 2; j++)
      for (int k = 0; k < 8; k++)
        o[2*k+j] = l[j*8+k];
    return o;
  endfunction

  function automatic int span_of(input logic [7:0] op);
    case (op)
      8'h03, 8'h02, 8'hA2, 8'h32: return 3;
      8'h0B, 8'h3B, 8'h6B, 8'hBB: return 4;
      8'hEB: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic step_model(input bit cs, input bit fired, input logic [7:0] op);
    if (!cs) begin
      m_mode = 0; m_left = 0;
    end else if (fired) begin
      if (m_mode == 0) begin
        if (span_of(op) == 0) m_mode = 1;
        else begin m_mode = 2; m_left = span_of(op); end
      end else if (m_mode == 2) begin
        if (m_left == 1) m_mode = 3;
        else m_left--;
      end
    end
  endtask

  task automatic beat(input string tag, input logic [15:0] head, input int level,
                      input int space, input logic [15:0] lin,
                      input bit cs = 1, input bit lmode = 0);
    bit strip, fire;
    int need;
    exp_t e;
    @(negedge clk);
    beat_go = 1; tx_head = head; tx_level = 9'(level); rx_space = 9'(space);
    lane_in = lin; cs_any = cs; linear_mode = lmode;
    #1;
    strip = (m_mode == 3);
    need  = strip ? 2 : 1;
    fire  = (level >= need);
    chk(striping == strip, tag, "striping", 32'(striping), 32'(strip));
    chk(tx_pop == fire, tag, "tx_pop", 32'(tx_pop), 32'(fire));
    chk(int'(tx_pop_cnt) == (fire ? need : 0), tag, "tx_pop_cnt",
        32'(tx_pop_cnt), 32'(fire ? need : 0));
    chk(lane_out == (fire ? (strip ? spread(head) : {2{head[7:0]}}) : 16'h0),
        tag, "lane_out", 32'(lane_out),
        32'(fire ? (strip ? spread(head) : {2{head[7:0]}}) : 16'h0));
    e.push = fire && (space >= need);
    e.cnt  = e.push ? need : 0;
    e.data = strip ? gather(lin) : {8'h00, lin[7:0]};
    e.ovf  = fire && (space < need);
    e.unf  = !fire && !lmode;
    e.tag  = tag;
    sb.push_back(e);
    step_model(cs, fire, head[7:0]);
  endtask

  task automatic idle(input string tag, input bit cs = 1);
    @(negedge clk);
    beat_go = 0; cs_any = cs;
    #1;
    chk(!tx_pop && !lane_strobe, tag, "idle pop", 32'(tx_pop), 32'h0);
    step_model(cs, 1'b0, 8'h00);
  endtask

  // monitor: compares registered results one cycle after each beat
  always @(negedge clk) begin
    if (mon_en) begin
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(rx_push == e.push, e.tag, "rx_push", 32'(rx_push), 32'(e.push));
        chk(int'(rx_push_cnt) == e.cnt, e.tag, "rx_push_cnt", 32'(rx_push_cnt), 32'(e.cnt));
        if (e.push) chk(rx_data == e.data, e.tag, "rx_data", 32'(rx_data), 32'(e.data));
        chk(ev_rx_overflow == e.ovf, e.tag, "ev_rx_overflow", 32'(ev_rx_overflow), 32'(e.ovf));
        chk(ev_tx_underflow == e.unf, e.tag, "ev_tx_underflow", 32'(ev_tx_underflow), 32'(e.unf));
      end else begin
        chk(!rx_push && !ev_rx_overflow && !ev_tx_underflow, "R10", "idle outputs",
            32'({rx_push, ev_rx_overflow, ev_tx_underflow}), 32'h0);
      end
    end
  end

  task automatic frame_end();
    idle("R7", 0);
    idle("R7", 1);
  endtask

  task automatic run_cmd(input logic [7:0] op, input int dups, input string tag);
    beat(tag, {8'h00, op}, 4, 8, 16'h5AC3);
    for (int i = 0; i < dups; i++)
      beat(tag, 16'h1200 | 16'(i), 4, 8, 16'h0F00 | 16'(i));
    chk(m_mode == 3, tag, "model reaches stripe", 32'(m_mode), 32'd3);
    beat("R5", 16'hA5C3, 4, 8, 16'h3C96);
    beat("R6", 16'h1234, 2, 2, 16'hF00F);
  endtask

  initial begin
    rst_n = 0; cs_any = 0; linear_mode = 0; beat_go = 0;
    tx_level = '0; rx_space = '0; tx_head = '0; lane_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    chk(!striping, "R1", "striping", 32'(striping), 32'h0);
    chk(!rx_push && !ev_rx_overflow && !ev_tx_underflow, "R1", "reset outputs",
        32'({rx_push, ev_rx_overflow, ev_tx_underflow}), 32'h0);
    chk(!tx_pop, "R1", "tx_pop", 32'(tx_pop), 32'h0);
    mon_en = 1;
    idle("R10", 1);

    // R3: each command class counts down into striping
    run_cmd(8'h03, 3, "R3");
    frame_end();
    run_cmd(8'hA2, 3, "R3");
    frame_end();
    run_cmd(8'h0B, 4, "R3");
    frame_end();
    run_cmd(8'hBB, 4, "R3");
    frame_end();
    run_cmd(8'hEB, 6, "R3");
    // R10: idle beats leave striping unchanged
    idle("R10", 1);
    beat("R10", 16'hFFEE, 2, 4, 16'h8001);

    // R8: overflow in striped mode (one slot, two needed)
    beat("R8", 16'h0F0F, 2, 1, 16'h1111);
    // R9: partial TX in striped mode, then suppressed by linear mode
    beat("R9", 16'h0101, 1, 4, 16'h2222);
    beat("R9", 16'h0101, 1, 4, 16'h2222, 1, 1);
    beat("R9", 16'h0101, 0, 4, 16'h2222);
    // R7: beat while chip select is low still sends, then state returns to checking
    beat("R7", 16'h7788, 2, 4, 16'h3344, 0);
    idle("R7", 1);

    // R4: unknown command stays duplicated
    beat("R4", 16'h009F, 1, 4, 16'h00AA);
    for (int i = 0; i < 8; i++)
      beat("R4", 16'h0300 | 16'(i), 2, 4, 16'hBB00 | 16'(i));
    frame_end();

    // R2 / R8 / R9 in checking and counting modes
    beat("R9", 16'h0003, 0, 4, 16'h0000);
    beat("R2", 16'h0032, 1, 4, 16'h77CC);
    beat("R8", 16'h0099, 1, 0, 16'h1234);
    beat("R2", 16'h00AB, 3, 1, 16'h66DD);
    beat("R2", 16'h00CD, 3, 1, 16'h55EE);
    beat("R5", 16'hFF00, 2, 2, 16'h00FF);
    frame_end();

    idle("R10", 1);
    idle("R10", 1);
    mon_en = 0;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule